// File: doc/BRIEF.md
# Per-instruction adaptive clock period controller

This block decides how long each instruction gets on the datapath. Every instruction arrives with a predicted delay class from an external classifier. The block turns that class into an execution window, measured in ticks of a fast base clock, by reading a small table of programmable periods. A registered lookup stage captures the instruction and its period. A window state machine then holds the window open for exactly that many ticks and commits the result at the last tick.

If the datapath raises its late-arrival flag on the last tick, the predicted class was too optimistic. In that case the result is discarded and the same instruction runs again at the worst-case period, which is the top entry of the table. A saturating counter keeps a tally of these replays.

The instruction input follows valid/ready rules. A transfer happens on any rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while the block is idle or in the cycle an instruction commits. A source that sees `in_ready` low must hold its instruction and class stable. The period table, the error flag and the counter clear are plain control pins. The number of classes is a parameter, 2 for a coarse split or 4 for a fine one.

Top module: `pc_adaptive_period`

## Requirements
- R1: An accepted instruction of class k gets a window (`win_open` high) of exactly T[k] consecutive cycles. During that window `cur_ticks` equals T[k] and `exec_instr` equals the instruction. T[k] is table entry k.
- R2: The class input is log2(NUM_CLASSES) bits wide and class value k selects entry k. Entry NUM_CLASSES-1 is the worst-case period.
- R3: After an instruction is accepted, there is exactly one lookup cycle with `win_open` low, and the window opens in the cycle after it.
- R4: If `late_err` is high in the last cycle of a first attempt, `replay` pulses in that cycle. A second window then starts in the next cycle, with no lookup cycle. It lasts the worst-case period, whatever the original class.
- R5: `late_err` has no effect in any cycle other than the last cycle of a first attempt. This covers earlier cycles of a window and the whole of a replay window, which always commits.
- R6: In the cycle an instruction commits, `in_ready` is high. An instruction offered then is accepted, and after one lookup cycle its window opens with its own period. The gap between windows is the same whether or not the period changes.
- R7: `in_ready` is low in the lookup cycle and in every window cycle except a committing one.
- R8: `done_valid` is high for exactly one cycle per committed instruction, namely the last cycle of its final window. It is never high for a flushed attempt.
- R9: A write with `cfg_we` high stores `cfg_ticks` into entry `cfg_idx` from the next cycle on, and a write of 0 stores 1. After reset, entry k holds (k+1)*STEP_TICKS.
- R10: `replay_count` increases by one per `replay` pulse and stops at its maximum, 2^CNT_W-1. When `cnt_clr` is high, the count is 0 in the next cycle, and the clear takes priority over an increment.
- R11: A synchronous reset (`rst` high at a rising edge) ends any window. It sets `in_ready` high, `win_open` low, `cur_ticks` to NUM_CLASSES*STEP_TICKS, `replay_count` to 0 and the table to its reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast base clock; one cycle is one tick |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Block can take an instruction this cycle |
| in_instr | input | DATA_W | Instruction word |
| in_class | input | CLS_W | Predicted delay class |
| cfg_we | input | 1 | Period table write enable |
| cfg_idx | input | CLS_W | Table entry to write |
| cfg_ticks | input | TICK_W | Period in ticks to write (0 stored as 1) |
| late_err | input | 1 | Late-arrival flag from the datapath |
| win_open | output | 1 | Execution window open |
| exec_instr | output | DATA_W | Instruction under execution |
| cur_ticks | output | TICK_W | Period of the current or most recent attempt |
| done_valid | output | 1 | Result of `exec_instr` committed this cycle |
| replay | output | 1 | Attempt flushed, replay at worst case follows |
| cnt_clr | input | 1 | Clears the replay counter |
| replay_count | output | CNT_W | Saturating replay tally |

## Verification
The properties assume a class value always names a real table entry. With 2 or 4 classes every encoding does, so no further input constraint is needed. They also assume that `in_instr` and `in_class` stay stable while `in_valid` waits, and that `late_err` is a clean level in every cycle. The replay-period check compares against the worst entry as it stood in the flagging cycle, so table writes at any time stay inside the assumptions. The stimulus changes every input on the falling edge only. It writes the table only between instructions and holds the error flag high on non-final ticks in some vectors, so that R5 is exercised without leaving the assumed input space.

// File: rtl/pc_pkg.sv
package pc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_RUN  = 2'd2
  } pc_state_e;
endpackage

// File: rtl/pc_period_tbl.sv
// Programmable period table; one register per delay class.
module pc_period_tbl #(
  parameter int NUM_CLASSES = 4,
  parameter int CLS_W       = 2,
  parameter int TICK_W      = 8,
  parameter int STEP_TICKS  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CLS_W-1:0]  widx,
  input  logic [TICK_W-1:0] wval,
  input  logic [CLS_W-1:0]  ridx,
  output logic [TICK_W-1:0] rdata,
  output logic [TICK_W-1:0] worst
);
  logic [TICK_W-1:0] ent [NUM_CLASSES];
  logic [TICK_W-1:0] wval_sat;

  // a period of zero ticks is meaningless; keep every entry >= 1 (R9)
  assign wval_sat = (wval == '0) ? TICK_W'(1) : wval;

  for (genvar g = 0; g < NUM_CLASSES; g++) begin : g_ent
    localparam int RST_VAL = (g + 1) * STEP_TICKS;
    logic [TICK_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)
        q <= TICK_W'(RST_VAL);
      else if (we && widx == CLS_W'(g))
        q <= wval_sat;
    end
    assign ent[g] = q;
  end

  assign rdata = ent[ridx];
  assign worst = ent[NUM_CLASSES-1];
endmodule

// File: rtl/pc_lookup.sv
// One-cycle registered lookup: captures instruction and its period.
module pc_lookup #(
  parameter int DATA_W    = 16,
  parameter int TICK_W    = 8,
  parameter int RST_TICKS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] instr_in,
  input  logic [TICK_W-1:0] ticks_in,
  input  logic              force_worst,
  input  logic [TICK_W-1:0] worst,
  output logic [DATA_W-1:0] instr_q,
  output logic [TICK_W-1:0] ticks_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      instr_q <= '0;
      ticks_q <= TICK_W'(RST_TICKS);
    end else if (force_worst) begin
      ticks_q <= worst;
    end else if (load) begin
      instr_q <= instr_in;
      ticks_q <= ticks_in;
    end
  end
endmodule

// File: rtl/pc_window_fsm.sv
// Window sequencer: lookup cycle, tick countdown, replay on late flag.
module pc_window_fsm
  import pc_pkg::*;
#(
  parameter int TICK_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              late_err,
  input  logic [TICK_W-1:0] ticks,
  input  logic [TICK_W-1:0] worst,
  output logic              in_ready,
  output logic              load,
  output logic              retry,
  output logic              commit,
  output logic              win_open
);
  pc_state_e         st;
  logic [TICK_W-1:0] tcnt;
  logic              rep;
  logic              last;

  always_comb begin
    win_open = (st == ST_RUN);
    last     = (tcnt == TICK_W'(1));
    retry    = win_open && last && late_err && !rep;
    commit   = win_open && last && !retry;
    in_ready = (st == ST_IDLE) || commit;
    load     = in_valid && in_ready;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      tcnt <= '0;
      rep  <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (load) st <= ST_LOOK;
        ST_LOOK: begin
          tcnt <= ticks;
          rep  <= 1'b0;
          st   <= ST_RUN;
        end
        ST_RUN: begin
          if (retry) begin
            tcnt <= worst;
            rep  <= 1'b1;
          end else if (!last) begin
            tcnt <= tcnt - TICK_W'(1);
          end else begin
            st <= load ? ST_LOOK : ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pc_replay_ctr.sv
// Saturating replay counter with synchronous clear.
module pc_replay_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst || clr)
      count <= '0;
    else if (inc && count != CNT_MAX)
      count <= count + CNT_W'(1);
  end
endmodule

// File: rtl/pc_adaptive_period.sv
module pc_adaptive_period #(
  parameter int DATA_W      = 16,
  parameter int NUM_CLASSES = 4,
  parameter int TICK_W      = 8,
  parameter int STEP_TICKS  = 2,
  parameter int CNT_W       = 8,
  localparam int CLS_W      = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_instr,
  input  logic [CLS_W-1:0]  in_class,
  input  logic              cfg_we,
  input  logic [CLS_W-1:0]  cfg_idx,
  input  logic [TICK_W-1:0] cfg_ticks,
  input  logic              late_err,
  output logic              win_open,
  output logic [DATA_W-1:0] exec_instr,
  output logic [TICK_W-1:0] cur_ticks,
  output logic              done_valid,
  output logic              replay,
  input  logic              cnt_clr,
  output logic [CNT_W-1:0]  replay_count
);
  localparam int RST_TICKS = NUM_CLASSES * STEP_TICKS;

  logic [TICK_W-1:0] tbl_rdata;
  logic [TICK_W-1:0] worst_ticks;
  logic              load;
  logic              retry;
  logic              commit;

  pc_period_tbl #(
    .NUM_CLASSES(NUM_CLASSES), .CLS_W(CLS_W),
    .TICK_W(TICK_W), .STEP_TICKS(STEP_TICKS)
  ) u_tbl (
    .clk(clk), .rst(rst),
    .we(cfg_we), .widx(cfg_idx), .wval(cfg_ticks),
    .ridx(in_class), .rdata(tbl_rdata), .worst(worst_ticks)
  );

  pc_lookup #(
    .DATA_W(DATA_W), .TICK_W(TICK_W), .RST_TICKS(RST_TICKS)
  ) u_look (
    .clk(clk), .rst(rst), .load(load),
    .instr_in(in_instr), .ticks_in(tbl_rdata),
    .force_worst(retry), .worst(worst_ticks),
    .instr_q(exec_instr), .ticks_q(cur_ticks)
  );

  pc_window_fsm #(.TICK_W(TICK_W)) u_fsm (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .late_err(late_err),
    .ticks(cur_ticks), .worst(worst_ticks),
    .in_ready(in_ready), .load(load),
    .retry(retry), .commit(commit), .win_open(win_open)
  );

  pc_replay_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst(rst), .inc(retry), .clr(cnt_clr), .count(replay_count)
  );

  assign done_valid = commit;
  assign replay     = retry;
endmodule

// File: rtl/pc_adaptive_period_chk.sv
module pc_adaptive_period_chk #(
  parameter int TICK_W = 8,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              win_open,
  input logic [TICK_W-1:0] cur_ticks,
  input logic              done_valid,
  input logic              replay,
  input logic              cnt_clr,
  input logic [CNT_W-1:0]  replay_count,
  input logic [TICK_W-1:0] worst_ticks
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  AST_LOOKUP_CLOSED: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !win_open); // R3
  AST_LOOKUP_OPENS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> ##1 win_open); // R3
  AST_REPLAY_WORST: assert property (@(posedge clk) disable iff (rst)
    replay |=> (win_open && cur_ticks == $past(worst_ticks))); // R4
  AST_SINGLE_REPLAY: assert property (@(posedge clk) disable iff (rst)
    replay |=> !replay); // R4
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    (win_open && !done_valid) |-> !in_ready); // R7
  AST_FLUSH_NO_DONE: assert property (@(posedge clk) disable iff (rst)
    replay |-> !done_valid); // R8
  AST_DONE_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> win_open); // R8
  AST_TICKS_NONZERO: assert property (@(posedge clk) disable iff (rst)
    cur_ticks != '0); // R9
  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (replay_count == CMAX && !cnt_clr) |=> replay_count == CMAX); // R10
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    cnt_clr |=> replay_count == '0); // R10
endmodule

bind pc_adaptive_period pc_adaptive_period_chk #(
  .TICK_W(TICK_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .win_open(win_open), .cur_ticks(cur_ticks), .done_valid(done_valid),
  .replay(replay), .cnt_clr(cnt_clr), .replay_count(replay_count),
  .worst_ticks(worst_ticks)
);

// File: tb/test_pc_adaptive_period.sv
`timescale 1ns/1ps
module test_pc_adaptive_period;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_ready;
  logic [15:0] in_instr;
  logic [1:0]  in_class;
  logic        cfg_we;
  logic [1:0]  cfg_idx;
  logic [7:0]  cfg_ticks;
  logic        late_err;
  logic        win_open;
  logic [15:0] exec_instr;
  logic [7:0]  cur_ticks;
  logic        done_valid;
  logic        replay;
  logic        cnt_clr;
  logic [2:0]  replay_count;

  int n_cmp = 0;
  int n_mis = 0;

  always #5 clk = ~clk;

  pc_adaptive_period #(
    .DATA_W(16), .NUM_CLASSES(4), .TICK_W(8), .STEP_TICKS(2), .CNT_W(3)
  ) i_pc_adaptive_period (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .in_class(in_class), .cfg_we(cfg_we),
    .cfg_idx(cfg_idx), .cfg_ticks(cfg_ticks), .late_err(late_err),
    .win_open(win_open), .exec_instr(exec_instr), .cur_ticks(cur_ticks),
    .done_valid(done_valid), .replay(replay), .cnt_clr(cnt_clr),
    .replay_count(replay_count)
  );

  // {instr, class, late on last tick, err on other ticks, first ticks, replay ticks}
  localparam int NV = 8;
  localparam logic [35:0] VEC [NV] = '{
    {16'hA001, 2'd0, 1'b0, 1'b0, 8'd2, 8'd0},
    {16'hA002, 2'd3, 1'b0, 1'b1, 8'd8, 8'd0},
    {16'hA003, 2'd1, 1'b1, 1'b0, 8'd4, 8'd8},
    {16'hA004, 2'd2, 1'b0, 1'b0, 8'd6, 8'd0},
    {16'hA005, 2'd0, 1'b1, 1'b1, 8'd2, 8'd8},
    {16'hA006, 2'd3, 1'b1, 1'b0, 8'd8, 8'd8},
    {16'hA007, 2'd1, 1'b0, 1'b1, 8'd4, 8'd0},
    {16'hA008, 2'd2, 1'b1, 1'b0, 8'd6, 8'd8}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_mis++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drives one instruction through lookup, window and optional replay
  task automatic exec(input logic [15:0] ins, input logic [1:0] cls,
                      input logic late, input logic noise,
                      input int nf, input int nr);
    @(negedge clk);
    chk("R7 ready when idle", int'(in_ready), 1);
    in_valid = 1'b1; in_instr = ins; in_class = cls;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R3 lookup cycle closed", int'(win_open), 0);
    chk("R7 not ready in lookup", int'(in_ready), 0);
    for (int t = 1; t <= nf; t++) begin
      @(negedge clk);
      late_err = (t == nf) ? late : noise;
      #1;
      chk("R1 window open", int'(win_open), 1);
      chk("R1 period", int'(cur_ticks), nf);
      chk("R1 instr", int'(exec_instr), int'(ins));
      if (t == nf) begin
        chk("R8 done on commit only", int'(done_valid), int'(!late));
        chk("R4 replay on late last tick", int'(replay), int'(late));
      end else begin
        chk("R5 no early action", int'(done_valid | replay), 0);
        chk("R7 busy not ready", int'(in_ready), 0);
      end
    end
    if (late) begin
      for (int t = 1; t <= nr; t++) begin
        @(negedge clk);
        late_err = 1'b1;
        #1;
        chk("R4 replay window", int'(win_open), 1);
        chk("R4 worst period", int'(cur_ticks), nr);
        chk("R5 err ignored in replay", int'(replay), 0);
        chk("R8 single done", int'(done_valid), int'(t == nr));
      end
    end
    @(negedge clk);
    late_err = 1'b0;
    #1;
    chk("R1 window ended", int'(win_open), 0);
    chk("R7 ready after", int'(in_ready), 1);
  endtask

  task automatic wr_tbl(input logic [1:0] idx, input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_ticks = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_mis++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_instr = '0; in_class = '0;
    cfg_we = 1'b0; cfg_idx = '0; cfg_ticks = '0; late_err = 1'b0; cnt_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R11 reset state
    chk("R11 ready", int'(in_ready), 1);
    chk("R11 window closed", int'(win_open), 0);
    chk("R11 worst period", int'(cur_ticks), 8);
    chk("R11 count", int'(replay_count), 0);

    // R1 R2 R4 R5 R8: table walk, reset periods 2,4,6,8
    for (int v = 0; v < NV; v++) begin
      exec(VEC[v][35:20], VEC[v][19:18], VEC[v][17], VEC[v][16],
           int'(VEC[v][15:8]), int'(VEC[v][7:0]));
    end
    chk("R10 replay tally", int'(replay_count), 4);

    // R6: back to back, class 1 (4 ticks) then class 0 (2 ticks)
    @(negedge clk);
    in_valid = 1'b1; in_instr = 16'hB001; in_class = 2'd1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b1; in_instr = 16'hB002; in_class = 2'd0;
    #1;
    chk("R6 ready on commit", int'(in_ready), 1);
    chk("R6 commit", int'(done_valid), 1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R6 one lookup cycle", int'(win_open), 0);
    chk("R6 next instr", int'(exec_instr), 16'hB002);
    @(negedge clk);
    chk("R6 new period", int'(cur_ticks), 2);
    chk("R6 window opens", int'(win_open), 1);
    @(negedge clk);
    chk("R6 second commit", int'(done_valid), 1);
    @(negedge clk);
    chk("R6 idle", int'(win_open), 0);

    // R9: reprogram, zero write becomes 1
    wr_tbl(2'd1, 8'd3);
    wr_tbl(2'd0, 8'd0);
    exec(16'hC001, 2'd1, 1'b0, 1'b0, 3, 0);
    exec(16'hC002, 2'd0, 1'b0, 1'b1, 1, 0);
    wr_tbl(2'd3, 8'd5);
    // R2 R4: replay follows the reprogrammed top entry
    exec(16'hC003, 2'd0, 1'b1, 1'b0, 1, 5);
    chk("R10 count five", int'(replay_count), 5);
    exec(16'hC004, 2'd2, 1'b1, 1'b0, 6, 5);
    exec(16'hC005, 2'd1, 1'b1, 1'b0, 3, 5);
    exec(16'hC006, 2'd0, 1'b1, 1'b0, 1, 5);
    chk("R10 saturates", int'(replay_count), 7);
    @(negedge clk);
    cnt_clr = 1'b1;
    @(negedge clk);
    cnt_clr = 1'b0;
    chk("R10 clear", int'(replay_count), 0);

    // R11: reset in the middle of a window
    @(negedge clk);
    in_valid = 1'b1; in_instr = 16'hD001; in_class = 2'd2;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R11 window cut", int'(win_open), 0);
    chk("R11 ready again", int'(in_ready), 1);
    chk("R11 period back to worst", int'(cur_ticks), 8);
    // R9 table restored: class 1 back to 4
    exec(16'hD002, 2'd1, 1'b0, 1'b0, 4, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end
endmodule